// File: doc/BRIEF.md
# ADC Threshold Persistence Comparator

This block watches a stream of 16-bit conversion results and decides when the input has stayed loud for long enough. A result counts as loud when its magnitude is at or above a programmable threshold. Each loud result raises an 8-bit running count by one. A quiet result either lowers the count by one or sets it back to zero, depending on a policy input. When the count reaches a programmable limit, a sticky status flag and the interrupt line go high. The flag stays high until software clears it.

Results can be read as unsigned values or as two's complement values. In signed mode the block compares the absolute value of the result against the low 15 bits of the threshold. A strobe qualifies each result, and the count changes at most once per strobe. Dropping the enable input clears the count and the flag. The threshold and limit registers keep their values and can still be written while the block is disabled.

Top module: `adc_persist_cmp`

## Requirements
- R1: After reset the threshold reads 0x0000, the limit reads 0x01, the count reads 0x00, and the flag and interrupt are low.
- R2: A pulse on `thr_we` loads `wdata[15:0]` into the threshold, and a pulse on `lim_we` loads `wdata[7:0]` into the limit. Each new value is visible on the next cycle, and writes work whether or not the block is enabled.
- R3: When `fmt_signed`=0, the magnitude is the raw 16-bit result and is compared against all 16 threshold bits. A valid result whose magnitude is greater than or equal to the threshold raises the count by one.
- R4: When `fmt_signed`=1, the magnitude is the absolute value of the result read as two's complement, and it is compared against threshold bits [14:0] only. Threshold bit 15 has no effect in this mode.
- R5: In signed mode the input 0x8000 has magnitude 0x7FFF.
- R6: A valid result below the threshold lowers the count by one when `below_clr`=0, and sets the count to zero when `below_clr`=1.
- R7: The count holds at 0xFF when it would rise above it, and holds at 0x00 when it would fall below it.
- R8: The count changes only on cycles where `res_valid` is high. With `res_valid` low, `res_data` has no effect.
- R9: On any enabled cycle where the updated count equals the limit, the flag is set at that same clock edge. `irq` always equals the flag.
- R10: The flag is sticky. A high `flag_clr` clears it on the next edge, unless the set condition of R9 holds in that same cycle, in which case the flag stays set.
- R11: While `enable` is low, the count and the flag are held at zero and valid results are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_we | input | 1 | Write strobe for the threshold register |
| lim_we | input | 1 | Write strobe for the limit register |
| wdata | input | 16 | Register write data |
| enable | input | 1 | Function enable |
| below_clr | input | 1 | Quiet-result policy: 1 clears the count, 0 lowers it by one |
| fmt_signed | input | 1 | Result format: 1 is two's complement, 0 is unsigned |
| res_valid | input | 1 | A new conversion result is present |
| res_data | input | 16 | Conversion result |
| flag_clr | input | 1 | Clears the sticky flag |
| thr_q | output | 16 | Threshold register value |
| lim_q | output | 8 | Limit register value |
| cnt_q | output | 8 | Running count value (read only) |
| flag_q | output | 1 | Sticky threshold status flag |
| irq | output | 1 | Interrupt request |

## Verification
The two saturation points are the hardest states to reach from the ports. The bench reaches the top point by driving more than 255 consecutive loud results. It then drives more than 255 quiet results with the decrement policy to reach the floor. The set-beats-clear collision is another difficult case. To produce it, the bench first parks the count one step below the limit, then raises `flag_clr` in the same cycle as a loud result. A behavioural model checks every cycle. A final phase of random results, with the policy and format toggled, exercises the signed edge values.

// File: rtl/adc_persist_cmp.sv
module adc_persist_cmp #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_we,
  input  logic          lim_we,
  input  logic [DW-1:0] wdata,
  input  logic          enable,
  input  logic          below_clr,
  input  logic          fmt_signed,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          flag_clr,
  output logic [DW-1:0] thr_q,
  output logic [CW-1:0] lim_q,
  output logic [CW-1:0] cnt_q,
  output logic          flag_q,
  output logic          irq
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] neg_val, mag, thr_eff;
  logic          over;
  logic [CW-1:0] cnt_nxt;
  logic          flag_nxt;

  assign neg_val = ~res_data + 1'b1;

  always_comb begin
    if (!fmt_signed)
      mag = res_data;
    else if (res_data == MIN_NEG)
      mag = MAX_POS;
    else if (res_data[DW-1])
      mag = neg_val;
    else
      mag = {1'b0, res_data[DW-2:0]};
  end

  assign thr_eff = fmt_signed ? {1'b0, thr_q[DW-2:0]} : thr_q;
  assign over    = mag >= thr_eff;

  always_comb begin
    cnt_nxt = cnt_q;
    if (!enable)
      cnt_nxt = '0;
    else if (res_valid) begin
      if (over)
        cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      else if (below_clr)
        cnt_nxt = '0;
      else
        cnt_nxt = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    end
  end

  assign flag_nxt = enable & ((cnt_nxt == lim_q) | (flag_q & ~flag_clr));
  assign irq      = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      lim_q  <= CW'(1);
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (thr_we) thr_q <= wdata;
      if (lim_we) lim_q <= wdata[CW-1:0];
      cnt_q  <= cnt_nxt;
      flag_q <= flag_nxt;
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !res_valid) |=> $stable(cnt_q));

  p_disabled_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0 && !flag_q));

  p_no_wrap_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !below_clr && cnt_q == CNT_MAX) |=> (cnt_q >= CNT_MAX - 1'b1));

  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && res_valid && !below_clr) |=>
      ((cnt_q - $past(cnt_q)) == CW'(1) || ($past(cnt_q) - cnt_q) == CW'(1) || cnt_q == $past(cnt_q)));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && enable && !flag_clr) |=> flag_q);

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == flag_q);

endmodule

// File: tb/adc_persist_cmp_tb.sv
module adc_persist_cmp_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        thr_we = 0, lim_we = 0;
  logic [15:0] wdata = 0;
  logic        enable = 0, below_clr = 0, fmt_signed = 0;
  logic        res_valid = 0;
  logic [15:0] res_data = 0;
  logic        flag_clr = 0;
  logic [15:0] thr_q;
  logic [7:0]  lim_q, cnt_q;
  logic        flag_q, irq;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_thr = 0, m_lim = 1, m_cnt = 0, m_flag = 0;

  always #4 clk = ~clk;

  adc_persist_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .lim_we(lim_we), .wdata(wdata),
    .enable(enable), .below_clr(below_clr), .fmt_signed(fmt_signed),
    .res_valid(res_valid), .res_data(res_data), .flag_clr(flag_clr),
    .thr_q(thr_q), .lim_q(lim_q), .cnt_q(cnt_q), .flag_q(flag_q), .irq(irq)
  );

  function automatic int magnitude(int raw, bit sgn);
    int v;
    if (!sgn) return raw;
    v = (raw >= 32768) ? raw - 65536 : raw;
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr = 0; m_lim = 1; m_cnt = 0; m_flag = 0;
    end else begin
      int nc, th, mg;
      nc = m_cnt;
      th = fmt_signed ? (m_thr & 32'h7fff) : m_thr;
      mg = magnitude(int'(res_data), fmt_signed);
      if (!enable) nc = 0;
      else if (res_valid) begin
        if (mg >= th) nc = (m_cnt < 255) ? m_cnt + 1 : 255;
        else if (below_clr) nc = 0;
        else nc = (m_cnt > 0) ? m_cnt - 1 : 0;
      end
      m_flag = (enable && ((nc == m_lim) || (m_flag == 1 && !flag_clr))) ? 1 : 0;
      m_cnt = nc;
      if (thr_we) m_thr = int'(wdata);
      if (lim_we) m_lim = int'(wdata[7:0]);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      checks++;
      if (int'(thr_q) != m_thr || int'(lim_q) != m_lim || int'(cnt_q) != m_cnt ||
          int'(flag_q) != m_flag || irq != flag_q) begin
        errors++;
        $display("FAIL %s cycle %0d: actual thr=%h lim=%h cnt=%h flag=%b irq=%b expected thr=%h lim=%h cnt=%h flag=%0d",
                 cur_req, cyc, thr_q, lim_q, cnt_q, flag_q, irq, m_thr[15:0], m_lim[7:0], m_cnt[7:0], m_flag);
      end
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_thr(int v);
    thr_we = 1; wdata = 16'(v); tick(); thr_we = 0;
  endtask

  task automatic wr_lim(int v);
    lim_we = 1; wdata = 16'(v); tick(); lim_we = 0;
  endtask

  task automatic push(int v);
    res_valid = 1; res_data = 16'(v); tick(); res_valid = 0;
  endtask

  task automatic restart();
    enable = 0; tick(); enable = 1;
  endtask

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    cur_req = "R1";
    chk("R1 thr", int'(thr_q), 0); chk("R1 lim", int'(lim_q), 1);
    chk("R1 cnt", int'(cnt_q), 0); chk("R1 flag", int'(flag_q), 0);

    cur_req = "R2";
    wr_thr(16'h1234); wr_lim(8'hA5);
    chk("R2 thr", int'(thr_q), 16'h1234); chk("R2 lim", int'(lim_q), 8'hA5);
    wdata = 16'hFF07; lim_we = 1; tick(); lim_we = 0;
    chk("R2 lim low byte", int'(lim_q), 7);

    cur_req = "R3";
    wr_lim(8'hFF); wr_thr(16'h8000); fmt_signed = 0; below_clr = 0; enable = 1; tick();
    push(16'h8000); chk("R3 equal counts", int'(cnt_q), 1);
    push(16'hFFFF); chk("R3 above counts", int'(cnt_q), 2);
    push(16'h7FFF); chk("R3 below lowers", int'(cnt_q), 1);

    cur_req = "R4";
    restart(); fmt_signed = 1; wr_thr(16'h8005);
    push(16'hFFFB); chk("R4 -5 vs 5", int'(cnt_q), 1);
    push(16'h0005); chk("R4 +5 vs 5", int'(cnt_q), 2);
    push(16'hFFFC); chk("R4 -4 below", int'(cnt_q), 1);

    cur_req = "R5";
    wr_thr(16'h7FFF); restart();
    push(16'h8000); chk("R5 min neg", int'(cnt_q), 1);
    push(16'h8001); chk("R5 -32767", int'(cnt_q), 2);
    push(16'h7FFE); chk("R5 below", int'(cnt_q), 1);

    cur_req = "R6";
    fmt_signed = 0; wr_thr(100); restart();
    for (int i = 0; i < 4; i++) push(200);
    push(5); chk("R6 decrement", int'(cnt_q), 3);
    below_clr = 1; push(5); chk("R6 clear", int'(cnt_q), 0);
    below_clr = 0;

    cur_req = "R7";
    for (int i = 0; i < 300; i++) push(1000);
    chk("R7 top hold", int'(cnt_q), 255);
    for (int i = 0; i < 300; i++) push(1);
    chk("R7 floor hold", int'(cnt_q), 0);

    cur_req = "R8";
    push(1000); push(1000);
    res_valid = 0;
    for (int i = 0; i < 5; i++) begin res_data = 16'(i * 9000); tick(); end
    chk("R8 idle hold", int'(cnt_q), 2);

    cur_req = "R9";
    wr_lim(3); restart();
    push(1000); push(1000); chk("R9 below limit", int'(flag_q), 0);
    push(1000); chk("R9 at limit", int'(flag_q), 1); chk("R9 irq", int'(irq), 1);

    cur_req = "R10";
    push(1000); push(1); chk("R10 sticky", int'(flag_q), 1);
    push(1); chk("R10 cnt", int'(cnt_q), 2);
    flag_clr = 1; tick(); flag_clr = 0;
    chk("R10 cleared", int'(flag_q), 0);
    flag_clr = 1; push(1000); flag_clr = 0;
    chk("R10 set wins", int'(flag_q), 1);

    cur_req = "R11";
    enable = 0; tick();
    chk("R11 cnt zero", int'(cnt_q), 0); chk("R11 flag zero", int'(flag_q), 0);
    push(1000); chk("R11 ignored", int'(cnt_q), 0);
    wr_thr(16'h0042); chk("R11 write while off", int'(thr_q), 16'h0042);

    cur_req = "R3/R4/R6 random";
    enable = 1; wr_lim(6);
    for (int i = 0; i < 2000; i++) begin
      if (i % 97 == 0) begin fmt_signed = ~fmt_signed; below_clr = $urandom_range(0, 1); end
      if (i % 211 == 0) wr_thr($urandom_range(0, 65535));
      flag_clr = ($urandom_range(0, 7) == 0);
      res_valid = $urandom_range(0, 1);
      res_data = (i % 13 == 0) ? 16'h8000 : 16'($urandom_range(0, 65535));
      tick();
    end
    flag_clr = 0; res_valid = 0;
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule